// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds a small pool of waiting operations for one class of functional unit in an out-of-order pipeline. An operation enters through the issue port together with two source operands. Each operand is either a finished value or the tag of the producer that will later compute it. Storing a tag in place of a register name renames the register implicitly. Entries with a pending tag watch a shared result broadcast bus, which carries a 64-bit value and a 4-bit producer tag. An entry latches the value when the bus tag equals the tag it is waiting for.

When an entry holds both operand values it may be dispatched. Among all such entries the one issued earliest is offered to the functional unit first. Each entry owns a tag equal to a base value plus its index. That tag is returned at issue and sent out with the dispatched operation. The unit later broadcasts its result under this tag, and the broadcast frees the entry. A flush input empties the whole array in a single cycle.

Top module: `rs_station`

## Requirements
- R1: `issueReady` is high exactly when at least one entry is free. While every entry is occupied, an operation presented on the issue port is dropped: it never reaches dispatch.
- R2: At issue, an operand flagged ready keeps its supplied value. An operand flagged not ready stores its producer tag and waits for a broadcast carrying that tag.
- R3: A waiting entry whose pending tag equals `cdbTag` while `cdbValid` is high takes `cdbValue` at that edge. A broadcast with any other tag leaves it unchanged, and an operand that already holds a value is never overwritten.
- R4: An entry can be dispatched only when both operands hold values. `dispValid` rises in the cycle after the edge that captures the last missing operand.
- R5: When a broadcast matches a pending source tag in the same cycle that the operation is issued, the operand is taken from the bus at issue.
- R6: When several entries are ready at once, the entry issued earliest is dispatched first, whatever its index.
- R7: A dispatch offer stays on the outputs until `dispReady` is high. Once accepted, the entry is not offered again.
- R8: The tag of entry i is TAG_BASE + i, which is 8 + i with the defaults. A new operation goes into the lowest-index free entry, and `issueTag` reports that entry's tag. A dispatched entry becomes free at the edge where `cdbValid` is high and `cdbTag` equals its own tag.
- R9: `flush` frees every entry at the next edge. An issue presented in the same cycle is discarded, and `dispValid` is held low while `flush` is high.
- R10: After reset all entries are free, `issueReady` is 1 and `dispValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Frees every entry at the next edge |
| issueValid | input | 1 | An operation is offered for issue |
| issueOp | input | OP_W | Operation code to store |
| issueARdy | input | 1 | Source A holds a value |
| issueAVal | input | DATA_W | Source A value |
| issueATag | input | TAG_W | Source A producer tag |
| issueBRdy | input | 1 | Source B holds a value |
| issueBVal | input | DATA_W | Source B value |
| issueBTag | input | TAG_W | Source B producer tag |
| issueReady | output | 1 | A free entry exists |
| issueTag | output | TAG_W | Tag of the entry that would be written |
| cdbValid | input | 1 | Result broadcast is valid |
| cdbTag | input | TAG_W | Producer tag of the broadcast |
| cdbValue | input | DATA_W | Broadcast result value |
| dispValid | output | 1 | An operation is offered to the functional unit |
| dispReady | input | 1 | The functional unit accepts the offer |
| dispOp | output | OP_W | Offered operation code |
| dispA | output | DATA_W | Offered source A value |
| dispB | output | DATA_W | Offered source B value |
| dispTag | output | TAG_W | Tag under which the result must be broadcast |

## Verification
The bench keeps the default parameters: four entries, 64-bit data, 4-bit tags and a tag base of 8. With only four entries, the full-array stall and the drop of an issue attempted while full are reached after four issues. Tags 8 to 11 belong to the station and tags below 8 stand for outside producers, so wake-up and entry release can be driven separately. Four entries are also enough to free a low-index entry, refill it with a younger operation and show that age, not index, decides dispatch order.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    RS_FREE = 2'd0,
    RS_WAIT = 2'd1,
    RS_EXEC = 2'd2
  } rsState_e;

  // strobes from control to datapath, one per entry
  typedef struct packed {
    logic alloc;  // write the issue port into this entry
    logic sel;    // this entry drives the dispatch outputs
  } rsStrobe_t;

endpackage

// File: rtl/rs_age_picker.sv
module rs_age_picker #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] allocVec,
  input  logic [N-1:0] reqVec,
  output logic [N-1:0] grantVec
);

  // olderQ[i][j] set: entry i was allocated before entry j
  logic [N-1:0] olderQ [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) olderQ[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (allocVec[i]) olderQ[i][j] <= 1'b0;
          else if (allocVec[j] && (i != j)) olderQ[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grantVec[i] = reqVec[i];
      for (int j = 0; j < N; j++) begin
        if ((j != i) && reqVec[j] && olderQ[j][i]) grantVec[i] = 1'b0;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R6
  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec != '0) |-> (grantVec != '0)); // R6

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int N        = 4,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  issueValid,
  output logic                  issueReady,
  output logic [TAG_W-1:0]      issueTag,
  input  logic                  cdbValid,
  input  logic [TAG_W-1:0]      cdbTag,
  input  logic [N-1:0]          opsReady,
  output logic                  dispValid,
  input  logic                  dispReady,
  output logic [TAG_W-1:0]      dispTag,
  output rsStrobe_t [N-1:0]     stb
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  rsState_e state [N];

  logic [N-1:0] freeVec, waitVec, execVec;
  logic [N-1:0] allocSel, allocVec, grantVec, releaseVec;
  logic [IDX_W-1:0] allocIdx, dispIdx;
  logic accept, dispFire;

  function automatic logic [TAG_W-1:0] ownTag(input int idx);
    return TAG_W'(TAG_BASE + idx);
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      freeVec[i] = (state[i] == RS_FREE);
      waitVec[i] = (state[i] == RS_WAIT);
      execVec[i] = (state[i] == RS_EXEC);
      releaseVec[i] = execVec[i] && cdbValid && (cdbTag == ownTag(i));
    end
  end

  // lowest free index wins
  always_comb begin
    allocSel = '0;
    allocIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        allocSel    = '0;
        allocSel[i] = 1'b1;
        allocIdx    = IDX_W'(i);
      end
    end
  end

  assign issueReady = |freeVec;
  assign issueTag   = TAG_W'(TAG_BASE) + TAG_W'(allocIdx);
  assign accept     = issueValid && issueReady && !flush;
  assign allocVec   = accept ? allocSel : '0;

  rs_age_picker #(.N(N)) u_picker (
    .clk      (clk),
    .rstN     (rstN),
    .allocVec (allocVec),
    .reqVec   (waitVec & opsReady),
    .grantVec (grantVec)
  );

  always_comb begin
    dispIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grantVec[i]) dispIdx = IDX_W'(i);
    end
  end

  assign dispValid = (|grantVec) && !flush;
  assign dispTag   = TAG_W'(TAG_BASE) + TAG_W'(dispIdx);
  assign dispFire  = dispValid && dispReady;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      stb[i].alloc = allocVec[i];
      stb[i].sel   = grantVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) state[i] <= RS_FREE;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush)                         state[i] <= RS_FREE;
        else if (allocVec[i])              state[i] <= RS_WAIT;
        else if (dispFire && grantVec[i])  state[i] <= RS_EXEC;
        else if (releaseVec[i])            state[i] <= RS_FREE;
      end
    end
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (&freeVec)); // R9
  AST_DISP_OPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> ((grantVec & ~opsReady) == '0)); // R4
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady && !flush) |=> (flush || dispValid)); // R7
  AST_NO_REOFFER: assert property (@(posedge clk) disable iff (!rstN)
    ((grantVec & execVec) == '0)); // R7

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rstN)
      allocVec[g] |-> (state[g] == RS_FREE)); // R1
    AST_RELEASE_OWN_TAG: assert property (@(posedge clk) disable iff (!rstN)
      (execVec[g] && !flush && !(cdbValid && cdbTag == ownTag(g))) |=> execVec[g]); // R8
  end

endmodule

// File: rtl/rs_dpath.sv
module rs_dpath
  import rs_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rsStrobe_t [N-1:0]     stb,
  input  logic [OP_W-1:0]       issueOp,
  input  logic                  issueARdy,
  input  logic [DATA_W-1:0]     issueAVal,
  input  logic [TAG_W-1:0]      issueATag,
  input  logic                  issueBRdy,
  input  logic [DATA_W-1:0]     issueBVal,
  input  logic [TAG_W-1:0]      issueBTag,
  input  logic                  cdbValid,
  input  logic [TAG_W-1:0]      cdbTag,
  input  logic [DATA_W-1:0]     cdbValue,
  output logic [N-1:0]          opsReady,
  output logic [OP_W-1:0]       dispOp,
  output logic [DATA_W-1:0]     dispA,
  output logic [DATA_W-1:0]     dispB
);

  logic [OP_W-1:0]   opQ   [N];
  logic [DATA_W-1:0] aValQ [N];
  logic [DATA_W-1:0] bValQ [N];
  logic [TAG_W-1:0]  aTagQ [N];
  logic [TAG_W-1:0]  bTagQ [N];
  logic [N-1:0]      aRdyQ, bRdyQ;

  logic bypassA, bypassB;
  assign bypassA = !issueARdy && cdbValid && (cdbTag == issueATag);
  assign bypassB = !issueBRdy && cdbValid && (cdbTag == issueBTag);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wakeA, wakeB;
    assign wakeA = !aRdyQ[g] && cdbValid && (cdbTag == aTagQ[g]);
    assign wakeB = !bRdyQ[g] && cdbValid && (cdbTag == bTagQ[g]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opQ[g]   <= '0;
        aValQ[g] <= '0;
        bValQ[g] <= '0;
        aTagQ[g] <= '0;
        bTagQ[g] <= '0;
        aRdyQ[g] <= 1'b0;
        bRdyQ[g] <= 1'b0;
      end else if (stb[g].alloc) begin
        opQ[g]   <= issueOp;
        aTagQ[g] <= issueATag;
        bTagQ[g] <= issueBTag;
        aRdyQ[g] <= issueARdy || bypassA;
        bRdyQ[g] <= issueBRdy || bypassB;
        aValQ[g] <= issueARdy ? issueAVal : cdbValue;
        bValQ[g] <= issueBRdy ? issueBVal : cdbValue;
      end else begin
        if (wakeA) begin
          aRdyQ[g] <= 1'b1;
          aValQ[g] <= cdbValue;
        end
        if (wakeB) begin
          bRdyQ[g] <= 1'b1;
          bValQ[g] <= cdbValue;
        end
      end
    end

    assign opsReady[g] = aRdyQ[g] && bRdyQ[g];

    AST_WAKE_A: assert property (@(posedge clk) disable iff (!rstN)
      (!stb[g].alloc && wakeA) |=> (aRdyQ[g] && aValQ[g] == $past(cdbValue))); // R3
    AST_WAKE_B: assert property (@(posedge clk) disable iff (!rstN)
      (!stb[g].alloc && wakeB) |=> (bRdyQ[g] && bValQ[g] == $past(cdbValue))); // R3
    AST_KEEP_A: assert property (@(posedge clk) disable iff (!rstN)
      (!stb[g].alloc && aRdyQ[g]) |=> (aRdyQ[g] && $stable(aValQ[g]))); // R3
    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rstN)
      (stb[g].alloc && bypassA) |=> (aRdyQ[g] && aValQ[g] == $past(cdbValue))); // R5
    AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rstN)
      (stb[g].alloc && bypassB) |=> (bRdyQ[g] && bValQ[g] == $past(cdbValue))); // R5
  end

  // one-hot select, OR mux
  always_comb begin
    dispOp = '0;
    dispA  = '0;
    dispB  = '0;
    for (int i = 0; i < N; i++) begin
      if (stb[i].sel) begin
        dispOp = dispOp | opQ[i];
        dispA  = dispA  | aValQ[i];
        dispB  = dispB  | bValQ[i];
      end
    end
  end

endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int N        = 4,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic              issueARdy,
  input  logic [DATA_W-1:0] issueAVal,
  input  logic [TAG_W-1:0]  issueATag,
  input  logic              issueBRdy,
  input  logic [DATA_W-1:0] issueBVal,
  input  logic [TAG_W-1:0]  issueBTag,
  output logic              issueReady,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  output logic              dispValid,
  input  logic              dispReady,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispA,
  output logic [DATA_W-1:0] dispB,
  output logic [TAG_W-1:0]  dispTag
);

  rsStrobe_t [N-1:0] stb;
  logic [N-1:0]      opsReady;

  rs_ctrl #(.N(N), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .issueValid (issueValid),
    .issueReady (issueReady),
    .issueTag   (issueTag),
    .cdbValid   (cdbValid),
    .cdbTag     (cdbTag),
    .opsReady   (opsReady),
    .dispValid  (dispValid),
    .dispReady  (dispReady),
    .dispTag    (dispTag),
    .stb        (stb)
  );

  rs_dpath #(.N(N), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .issueOp   (issueOp),
    .issueARdy (issueARdy),
    .issueAVal (issueAVal),
    .issueATag (issueATag),
    .issueBRdy (issueBRdy),
    .issueBVal (issueBVal),
    .issueBTag (issueBTag),
    .cdbValid  (cdbValid),
    .cdbTag    (cdbTag),
    .cdbValue  (cdbValue),
    .opsReady  (opsReady),
    .dispOp    (dispOp),
    .dispA     (dispA),
    .dispB     (dispB)
  );

endmodule

// File: tb/rs_station_tb.sv
module rs_station_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        issueValid = 1'b0;
  logic [3:0]  issueOp = '0;
  logic        issueARdy = 1'b0;
  logic [63:0] issueAVal = '0;
  logic [3:0]  issueATag = '0;
  logic        issueBRdy = 1'b0;
  logic [63:0] issueBVal = '0;
  logic [3:0]  issueBTag = '0;
  logic        issueReady;
  logic [3:0]  issueTag;
  logic        cdbValid = 1'b0;
  logic [3:0]  cdbTag = '0;
  logic [63:0] cdbValue = '0;
  logic        dispValid;
  logic        dispReady = 1'b0;
  logic [3:0]  dispOp;
  logic [63:0] dispA;
  logic [63:0] dispB;
  logic [3:0]  dispTag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rs_station u_dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueARdy(issueARdy), .issueAVal(issueAVal), .issueATag(issueATag),
    .issueBRdy(issueBRdy), .issueBVal(issueBVal), .issueBTag(issueBTag),
    .issueReady(issueReady), .issueTag(issueTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue),
    .dispValid(dispValid), .dispReady(dispReady),
    .dispOp(dispOp), .dispA(dispA), .dispB(dispB), .dispTag(dispTag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic issue(input logic [3:0] op, input bit aR, input logic [63:0] aV,
                       input logic [3:0] aT, input bit bR, input logic [63:0] bV,
                       input logic [3:0] bT, input int expTag, input string req);
    issueValid = 1'b1; issueOp = op;
    issueARdy = aR; issueAVal = aV; issueATag = aT;
    issueBRdy = bR; issueBVal = bV; issueBTag = bT;
    settle();
    if (expTag >= 0) chkEq(req, "issueTag", issueTag, 64'(expTag));
    step();
    issueValid = 1'b0;
  endtask

  task automatic broadcast(input logic [3:0] t, input logic [63:0] v);
    cdbValid = 1'b1; cdbTag = t; cdbValue = v;
    step();
    cdbValid = 1'b0;
  endtask

  task automatic doFlush();
    flush = 1'b1;
    step();
    flush = 1'b0;
    settle();
  endtask

  task automatic testReset();
    settle();
    chkEq("R10", "issueReady after reset", issueReady, 1);
    chkEq("R10", "dispValid after reset", dispValid, 0);
  endtask

  task automatic testBasic();
    issue(4'd3, 1, 64'd100, 4'd0, 1, 64'd200, 4'd0, 8, "R8");
    settle();
    chkEq("R4", "dispValid next cycle", dispValid, 1);
    chkEq("R2", "dispOp", dispOp, 3);
    chkEq("R2", "dispA ready value", dispA, 100);
    chkEq("R2", "dispB ready value", dispB, 200);
    chkEq("R8", "dispTag", dispTag, 8);
    step();
    chkEq("R7", "offer held without dispReady", dispValid, 1);
    dispReady = 1'b1;
    step();
    dispReady = 1'b0;
    settle();
    chkEq("R7", "no offer after accept", dispValid, 0);
    issue(4'd4, 1, 64'd1, 4'd0, 1, 64'd2, 4'd0, 9, "R8");
    broadcast(4'd8, 64'hDEAD);
    settle();
    chkEq("R8", "entry freed by own tag", issueTag, 8);
    doFlush();
  endtask

  task automatic testWakeup();
    issue(4'd6, 0, 64'd0, 4'd2, 0, 64'd0, 4'd3, 8, "R8");
    settle();
    chkEq("R4", "pending operands block dispatch", dispValid, 0);
    broadcast(4'd5, 64'h11);
    settle();
    chkEq("R3", "other tag ignored", dispValid, 0);
    broadcast(4'd2, 64'hAA);
    settle();
    chkEq("R4", "one operand still pending", dispValid, 0);
    broadcast(4'd2, 64'hCC);
    broadcast(4'd3, 64'hBB);
    settle();
    chkEq("R4", "both captured -> dispatch", dispValid, 1);
    chkEq("R3", "dispA captured, not overwritten", dispA, 64'hAA);
    chkEq("R2", "dispB captured via tag", dispB, 64'hBB);
    doFlush();
  endtask

  task automatic testBypass();
    cdbValid = 1'b1; cdbTag = 4'd4; cdbValue = 64'h55;
    issue(4'd7, 0, 64'd0, 4'd4, 1, 64'd7, 4'd0, 8, "R5");
    cdbValid = 1'b0;
    settle();
    chkEq("R5", "bypass makes entry ready", dispValid, 1);
    chkEq("R5", "dispA from bus at issue", dispA, 64'h55);
    doFlush();
  endtask

  task automatic testOldest();
    issue(4'd1, 1, 64'd1, 4'd0, 1, 64'd1, 4'd0, 8, "R8");
    dispReady = 1'b1;
    step();
    dispReady = 1'b0;
    issue(4'd2, 0, 64'd0, 4'd1, 1, 64'd2, 4'd0, 9, "R8");
    issue(4'd3, 0, 64'd0, 4'd1, 1, 64'd3, 4'd0, 10, "R8");
    broadcast(4'd8, 64'h0);
    issue(4'd4, 0, 64'd0, 4'd1, 1, 64'd4, 4'd0, 8, "R8");
    broadcast(4'd1, 64'h77);
    dispReady = 1'b1;
    settle();
    chkEq("R6", "oldest first tag", dispTag, 9);
    chkEq("R6", "oldest first op", dispOp, 2);
    step();
    chkEq("R6", "second oldest tag", dispTag, 10);
    step();
    chkEq("R6", "youngest last (low index)", dispTag, 8);
    chkEq("R6", "youngest op", dispOp, 4);
    step();
    chkEq("R6", "all drained", dispValid, 0);
    dispReady = 1'b0;
    doFlush();
  endtask

  task automatic testFull();
    for (int k = 0; k < 4; k++)
      issue(4'(k + 1), 0, 64'd0, 4'd6, 1, 64'(k), 4'd0, 8 + k, "R8");
    settle();
    chkEq("R1", "issueReady low when full", issueReady, 0);
    issue(4'd9, 1, 64'd9, 4'd0, 1, 64'd9, 4'd0, -1, "R1");
    broadcast(4'd6, 64'h66);
    dispReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      settle();
      chkEq("R1", "dispatch tag in age order", dispTag, 64'(8 + k));
      chkEq("R1", "dispatch op not the dropped one", dispOp, 64'(k + 1));
      step();
    end
    chkEq("R1", "dropped issue never dispatched", dispValid, 0);
    dispReady = 1'b0;
    chkEq("R1", "still full while executing", issueReady, 0);
    broadcast(4'd10, 64'h0);
    settle();
    chkEq("R1", "issueReady after release", issueReady, 1);
    chkEq("R8", "freed entry index 2", issueTag, 10);
  endtask

  task automatic testFlush();
    flush = 1'b1;
    issue(4'd12, 1, 64'd5, 4'd0, 1, 64'd6, 4'd0, -1, "R9");
    flush = 1'b0;
    settle();
    chkEq("R9", "all free after flush", issueReady, 1);
    chkEq("R9", "issueTag lowest after flush", issueTag, 8);
    chkEq("R9", "issue during flush discarded", dispValid, 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    testReset();
    testBasic();
    testWakeup();
    testBypass();
    testOldest();
    testFull();
    testFlush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule